// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block is the private event timer of one processor core. It counts in two stages. A prescaler divides the clock into ticks. An interrupt counter counts those ticks and raises an interrupt flag when its count runs out. In interval mode the interrupt counter reloads itself and keeps firing at a fixed period. With interval mode off it fires once and then halts, so software gets one-shot behaviour by stopping the timer from its handler.

Software reaches the timer through a small word-addressed window. The window holds a prescaler buffer, an interrupt-count buffer, a control word, a sticky interrupt flag, an interrupt enable and a write-confirmation word. The window sits at `0x300 + 0x100 * CORE_IDX` in a shared address space. Every accepted buffer or control write sets a confirmation bit. Software clears that bit by writing 1 to it, so a driver can poll for the moment its write has landed.

Top module: `core_tick_timer`

## Requirements
- R1: Writes take effect only when `addr[11:8]` equals the upper bits of `0x300 + 0x100*CORE_IDX`. A write to any other window changes nothing, and a read outside the window returns 0.
- R2: After reset, every register reads 0 and `irq` is low.
- R3: The prescaler buffer (offset 0x00) reads back what was written. While the timer runs, the prescaler produces one tick every (buffer + 1) clock cycles.
- R4: A write to the interrupt-count buffer (offset 0x08) is accepted only when bit 31 of the data is 1. Bits 30:0 then hold the count, which reads back with bit 31 as 0. A write with bit 31 = 0 leaves the buffer unchanged.
- R5: The control word is at offset 0x20. Bit 0 runs the prescaler, bit 1 runs the interrupt counter and bit 2 selects interval mode. The status flag first sets exactly N*(T+1) cycles after the write that sets bits 0 and 1 together, where T is the prescaler buffer and N the interrupt-count buffer.
- R6: In interval mode, the status flag sets again every N*(T+1) cycles for as long as both run bits stay 1.
- R7: With bit 2 = 0, the interrupt counter halts after its first expiry and sets no further flag until it is restarted.
- R8: Bit 0 at offset 0x30 is the interrupt flag. Writing 1 to it clears it, and writing 0 leaves it as it is.
- R9: `irq` equals the flag ANDed with bit 0 of the enable register at offset 0x34. The flag sets even while that enable bit is 0.
- R10: The confirmation word is at offset 0x40. Bit 0 sets on a prescaler-buffer write, bit 1 on an accepted interrupt-count write and bit 3 on a control write. Writing 1 to a bit clears it.
- R11: Clearing bit 0 freezes both counting stages. Clearing bit 1 freezes only the interrupt counter. Setting a run bit again reloads its stage from its buffer, so the next flag comes a full period after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address in the shared timer space |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
Assertions check several behaviours on every cycle:
- each prescaler tick reloads the prescaler from its buffer;
- a stopped stage holds its count;
- a one-shot expiry retires the interrupt counter;
- every expiry sets the flag;
- an interrupt-count write without bit 31 leaves the buffer untouched;
- every control write raises its confirmation bit.

Some properties span whole periods, and only the bench scenarios show them. These are the exact cycle distance N*(T+1) for several divider and count pairs, the repeat period in interval mode, the absence of a second flag in one-shot mode, and reload rather than resume after a stop. The bench also shows window decode, and that the enable gates only the output and not the flag.

// File: rtl/tt_pkg.sv
package tt_pkg;

  localparam logic [7:0] OFF_TICK_BUF = 8'h00;
  localparam logic [7:0] OFF_INT_BUF  = 8'h08;
  localparam logic [7:0] OFF_CTRL     = 8'h20;
  localparam logic [7:0] OFF_FLAG     = 8'h30;
  localparam logic [7:0] OFF_IEN      = 8'h34;
  localparam logic [7:0] OFF_CONFIRM  = 8'h40;

  // confirmation bits that exist: 0 tick buffer, 1 interrupt buffer, 3 control
  localparam logic [3:0] CONFIRM_USED = 4'b1011;

  typedef struct packed {
    logic interval;  // bit 2
    logic int_run;   // bit 1
    logic tmr_run;   // bit 0
  } ctrl_t;

endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [7:0]        offset,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata,
  output logic [TICK_W-1:0] tick_buf,
  output logic [ICNT_W-1:0] int_buf,
  output ctrl_t             ctrl,
  output logic              int_en,
  output logic              flag
);

  localparam int UPD_BIT = DATA_W - 1;

  logic hit_tb, hit_ib, hit_ct, hit_fl, hit_en, hit_cf;
  logic [TICK_W-1:0] tick_buf_n;
  logic [ICNT_W-1:0] int_buf_n;
  ctrl_t             ctrl_n;
  logic              int_en_n, flag_n;
  logic [3:0]        conf_set;
  logic [3:0]        confirm;

  always_comb begin
    hit_tb = wr_en && sel && (offset == OFF_TICK_BUF);
    hit_ib = wr_en && sel && (offset == OFF_INT_BUF) && wdata[UPD_BIT];
    hit_ct = wr_en && sel && (offset == OFF_CTRL);
    hit_fl = wr_en && sel && (offset == OFF_FLAG);
    hit_en = wr_en && sel && (offset == OFF_IEN);
    hit_cf = wr_en && sel && (offset == OFF_CONFIRM);
  end

  always_comb begin
    tick_buf_n = hit_tb ? wdata[TICK_W-1:0] : tick_buf;
    int_buf_n  = hit_ib ? wdata[ICNT_W-1:0] : int_buf;
    ctrl_n     = hit_ct ? ctrl_t'(wdata[2:0]) : ctrl;
    int_en_n   = hit_en ? wdata[0] : int_en;
    flag_n     = expire | (flag & ~(hit_fl & wdata[0]));
    conf_set   = {hit_ct, 1'b0, hit_ib, hit_tb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_buf <= '0;
      int_buf  <= '0;
      ctrl     <= '0;
      int_en   <= 1'b0;
      flag     <= 1'b0;
    end else begin
      tick_buf <= tick_buf_n;
      int_buf  <= int_buf_n;
      ctrl     <= ctrl_n;
      int_en   <= int_en_n;
      flag     <= flag_n;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_confirm
    if (CONFIRM_USED[k]) begin : g_bit
      logic bit_n;
      always_comb bit_n = conf_set[k] | (confirm[k] & ~(hit_cf & wdata[k]));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) confirm[k] <= 1'b0;
        else        confirm[k] <= bit_n;
      end
    end else begin : g_none
      assign confirm[k] = 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (offset)
        OFF_TICK_BUF: rdata = DATA_W'(tick_buf);
        OFF_INT_BUF:  rdata = DATA_W'(int_buf);
        OFF_CTRL:     rdata = DATA_W'(ctrl);
        OFF_FLAG:     rdata = DATA_W'(flag);
        OFF_IEN:      rdata = DATA_W'(int_en);
        OFF_CONFIRM:  rdata = DATA_W'(confirm);
        default:      rdata = '0;
      endcase
    end
  end

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  assert_int_buf_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel && offset == OFF_INT_BUF && !wdata[UPD_BIT]) |=> $stable(int_buf));

  assert_confirm_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel && offset == OFF_CTRL) |=> confirm[3]);

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [TICK_W-1:0] tick_buf,
  output logic              tick
);

  logic [TICK_W-1:0] cnt_q, cnt_n;

  always_comb begin
    tick  = run && (cnt_q == '0);
    cnt_n = cnt_q;
    if (load)      cnt_n = tick_buf;
    else if (tick) cnt_n = tick_buf;
    else if (run)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assert_tick_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(tick_buf)));

  assert_prescale_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/tt_intcnt.sv
module tt_intcnt #(
  parameter int ICNT_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              int_run,
  input  logic              interval,
  input  logic              load,
  input  logic [ICNT_W-1:0] int_buf,
  output logic              expire
);

  localparam logic [ICNT_W-1:0] ONE = ICNT_W'(1);

  logic [ICNT_W-1:0] cnt_q, cnt_n;
  logic              active_q, active_n;
  logic              step;

  always_comb begin
    step     = tick && int_run && active_q && !load;
    expire   = step && (cnt_q <= ONE);
    cnt_n    = cnt_q;
    active_n = active_q;
    if (load) begin
      cnt_n    = int_buf;
      active_n = 1'b1;
    end else if (expire) begin
      if (interval) begin
        cnt_n = int_buf;
      end else begin
        cnt_n    = '0;
        active_n = 1'b0;
      end
    end else if (step) begin
      cnt_n = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      active_q <= active_n;
    end
  end

  assert_oneshot_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !interval) |=> !active_q);

  assert_int_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import tt_pkg::*;
#(
  parameter int CORE_IDX = 0,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int TICK_W   = 32,
  parameter int ICNT_W   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(32'h300 + 32'h100 * CORE_IDX);

  logic              rst_n_s;
  logic              sel;
  logic [7:0]        offset;
  logic [TICK_W-1:0] tick_buf;
  logic [ICNT_W-1:0] int_buf;
  ctrl_t             ctrl, ctrl_wr;
  logic              int_en, flag, tick, expire;
  logic              ctrl_hit, tmr_load, int_load;

  tt_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    sel      = (addr[ADDR_W-1:8] == WIN_BASE[ADDR_W-1:8]);
    offset   = addr[7:0];
    ctrl_wr  = ctrl_t'(wdata[2:0]);
    ctrl_hit = wr_en && sel && (offset == OFF_CTRL);
    tmr_load = ctrl_hit && ctrl_wr.tmr_run && !ctrl.tmr_run;
    int_load = ctrl_hit && ctrl_wr.int_run &&
               (!ctrl.int_run || (ctrl_wr.tmr_run && !ctrl.tmr_run));
  end

  tt_regs #(.DATA_W(DATA_W), .TICK_W(TICK_W), .ICNT_W(ICNT_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .sel      (sel),
    .offset   (offset),
    .wdata    (wdata),
    .expire   (expire),
    .rdata    (rdata),
    .tick_buf (tick_buf),
    .int_buf  (int_buf),
    .ctrl     (ctrl),
    .int_en   (int_en),
    .flag     (flag)
  );

  tt_prescaler #(.TICK_W(TICK_W)) presc_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (ctrl.tmr_run),
    .load     (tmr_load),
    .tick_buf (tick_buf),
    .tick     (tick)
  );

  tt_intcnt #(.ICNT_W(ICNT_W)) icnt_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick     (tick),
    .int_run  (ctrl.int_run),
    .interval (ctrl.interval),
    .load     (int_load),
    .int_buf  (int_buf),
    .expire   (expire)
  );

  assign irq = flag & int_en;

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && sel && offset == OFF_FLAG && wdata[0] && !expire) |=> !flag);

  assert_outside_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !sel) |=> $stable(ctrl));

endmodule

// File: tb/core_tick_timer_tb_top.sv
module core_tick_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  localparam logic [11:0] B = 12'h300;

  always #10 clk = ~clk;

  core_tick_timer dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_vec = n_vec + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
    addr = '0;
  endtask

  task automatic wait_irq(input int maxc, output int n);
    n = 0;
    while (n < maxc) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic quiet(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq) seen = 1;
    end
  endtask

  task automatic idle_all();
    wr(B + 12'h020, 32'h0);
    wr(B + 12'h030, 32'h1);
    wr(B + 12'h040, 32'hF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(B + 12'h000, d); check("R2 tick buf", d, 0);
    rd(B + 12'h008, d); check("R2 int buf", d, 0);
    rd(B + 12'h020, d); check("R2 ctrl", d, 0);
    rd(B + 12'h030, d); check("R2 flag", d, 0);
    rd(B + 12'h034, d); check("R2 enable", d, 0);
    rd(B + 12'h040, d); check("R2 confirm", d, 0);
    check("R2 irq", irq, 0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(12'h400, 32'h55);
    wr(12'h420, 32'h7);
    rd(B + 12'h000, d); check("R1 foreign tick buf write", d, 0);
    rd(B + 12'h020, d); check("R1 foreign ctrl write", d, 0);
    wr(B + 12'h000, 32'h1234);
    rd(12'h400, d); check("R1 read outside window", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(B + 12'h040, 32'hF);
    wr(B + 12'h000, 32'h0000_00A5);
    rd(B + 12'h000, d); check("R3 tick buf readback", d, 32'hA5);
    rd(B + 12'h040, d); check("R10 confirm tick", d, 32'h1);
    wr(B + 12'h008, 32'h0000_0077);
    rd(B + 12'h008, d); check("R4 int buf ignored", d, 0);
    rd(B + 12'h040, d); check("R10 no confirm on ignored", d, 32'h1);
    wr(B + 12'h008, 32'h8000_0123);
    rd(B + 12'h008, d); check("R4 int buf accepted", d, 32'h123);
    wr(B + 12'h020, 32'h4);
    rd(B + 12'h020, d); check("R5 ctrl readback", d, 32'h4);
    rd(B + 12'h040, d); check("R10 confirm all", d, 32'hB);
    wr(B + 12'h040, 32'h2);
    rd(B + 12'h040, d); check("R10 w1c bit1", d, 32'h9);
    wr(B + 12'h040, 32'h9);
    rd(B + 12'h040, d); check("R10 w1c rest", d, 32'h0);
    idle_all();
  endtask

  task automatic run_period(input int t, input int n, input int ctl, input string tag);
    int c;
    wr(B + 12'h000, t);
    wr(B + 12'h008, 32'h8000_0000 | n);
    wr(B + 12'h020, ctl);
    wait_irq(200, c);
    check(tag, c, n * (t + 1));
  endtask

  task automatic t_prescale();
    wr(B + 12'h034, 32'h1);
    run_period(0, 4, 3, "R3 divide by 1");
    idle_all();
    run_period(3, 2, 3, "R3 divide by 4");
    idle_all();
    run_period(1, 5, 3, "R5 first flag at N*(T+1)");
    idle_all();
  endtask

  task automatic t_oneshot();
    int s;
    logic [31:0] d;
    run_period(1, 5, 3, "R7 one-shot first");
    wr(B + 12'h030, 32'h0);
    rd(B + 12'h030, d); check("R8 write 0 keeps flag", d, 1);
    wr(B + 12'h030, 32'h1);
    rd(B + 12'h030, d); check("R8 w1c flag", d, 0);
    quiet(40, s); check("R7 no second flag", s, 0);
    idle_all();
  endtask

  task automatic t_interval();
    int c;
    run_period(2, 3, 7, "R6 interval first");
    for (int k = 0; k < 3; k++) begin
      wr(B + 12'h030, 32'h1);
      wait_irq(100, c);
      check("R6 interval repeat", c, 8);
    end
    idle_all();
  endtask

  task automatic t_enable();
    int s;
    logic [31:0] d;
    wr(B + 12'h034, 32'h0);
    wr(B + 12'h000, 32'h0);
    wr(B + 12'h008, 32'h8000_0003);
    wr(B + 12'h020, 32'h3);
    quiet(6, s); check("R9 irq masked", s, 0);
    rd(B + 12'h030, d); check("R9 flag sets while masked", d, 1);
    wr(B + 12'h034, 32'h1);
    check("R9 irq after enable", irq, 1);
    idle_all();
  endtask

  task automatic t_freeze();
    int s, c;
    wr(B + 12'h000, 32'h1);
    wr(B + 12'h008, 32'h8000_0005);
    wr(B + 12'h020, 32'h7);
    repeat (4) begin @(posedge clk); @(negedge clk); end
    wr(B + 12'h020, 32'h4);
    quiet(30, s); check("R11 timer stop freezes", s, 0);
    wr(B + 12'h020, 32'h7);
    wait_irq(100, c); check("R11 restart reloads", c, 10);
    idle_all();
    wr(B + 12'h020, 32'h7);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    wr(B + 12'h020, 32'h5);
    quiet(30, s); check("R11 int stop freezes", s, 0);
    wr(B + 12'h020, 32'h7);
    wait_irq(100, c); check("R11 int restart full period", (c >= 9 && c <= 10), 1);
    idle_all();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    t_reset();
    t_window();
    t_regs();
    t_prescale();
    t_oneshot();
    t_interval();
    t_enable();
    t_freeze();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule